// File: doc/BRIEF.md
# Programmable Delayed Event Combiner

This block sits beside a real-time counter in the low-frequency clock domain. It takes event pulses from three compare channels and produces a delayed copy of each pulse. The delay is a count of low-frequency clock cycles, and one 4-bit code sets it for all channels at once. The code follows a non-linear scale. The lower codes double from one cycle up to thirty-two cycles. The upper codes then rise in steps of sixteen, up to a ceiling of 144 cycles.

A 3-bit mask picks which delayed pulses feed a single combined event. The combined event is the OR of the picked pulses. A single control register holds the global enable, two stored option bits, the delay code, the mask and a self-clearing bit. Setting that bit clears the free-running counter that the block keeps. While the enable bit is low, the whole block freezes and emits nothing.

Top module: `evt_delay_combiner`

## Requirements
- R1: After reset, every output is 0, the control register reads 0 and the counter reads 0.
- R2: For delay codes 1 to 13, a channel pulse sampled in enabled cycle k produces one delayed pulse in enabled cycle k+D. D is 1, 2, 4, 8, 16, 32, 48, 64, 80, 96, 112, 128 or 144 for codes 1 to 13 in turn.
- R3: Codes 14 and 15 give a delay of 144 cycles.
- R4: Code 0 passes a channel pulse to that channel's delayed output in the same cycle.
- R5: A new pulse on a channel whose delay is still running restarts that channel's count from the full delay, and the earlier pending pulse is dropped. A count that reaches its output cycle still fires in that cycle, even if a new pulse arrives in the same cycle.
- R6: The combined output is the OR of the delayed outputs whose mask bit is set. Mask bit i selects channel i. With a mask of 0, the combined output stays 0.
- R7: While the enable bit is 0, no delayed or combined pulse appears. Channel inputs are ignored, and running counts hold their value and resume when enable returns.
- R8: The counter increases by 1 on each clock edge while the enable bit is 1, and holds its value while the enable bit is 0.
- R9: Writing 1 to bit 7 makes bit 7 read 1 for one cycle. On the next edge the counter becomes 0 and bit 7 reads 0. Writing 0 to bit 7 has no effect.
- R10: The control fields are laid out as follows: enable at bit 0, two stored option bits at bits 1 and 2, the counter-reset bit at bit 7, the delay code at bits 11:8 and the mask at bits 18:16. A write takes effect on the next edge. All other bits read 0.
- R11: Each delayed pulse and each combined pulse lasts exactly one clock cycle for each input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lf_clk | input | 1 | Low-frequency clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read data |
| chan_evt | input | 3 | One-cycle event pulses from the compare channels |
| dly_evt | output | 3 | Delayed event pulses, one per channel |
| comb_evt | output | 1 | Masked OR of the delayed events |
| rtc_count | output | CNT_W | Free-running counter value |

## Verification
The hardest cases to reach are the long codes and the timing overlaps. Codes 13 to 15 need 144 quiet cycles before the output appears. In the restart case, a second pulse lands in the middle of a running count. In the freeze case, the enable bit drops while a count is part-way done. The stimulus sweeps every code with a single pulse and waits past the expected due cycle. It then fires a second pulse a few cycles into a running count, and it clears the enable bit mid-count while pulsing the inputs. A behavioural model tracks each channel's due cycle as an integer count of enabled cycles and compares its result with every output on each clock.

// File: rtl/evdly_pkg.sv
package evdly_pkg;
  localparam int NUM_CH   = 3;
  localparam int CODE_W   = 4;
  localparam int DLY_W    = 8;
  localparam int REG_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int UPD_BIT  = 1;
  localparam int KHZ_BIT  = 2;
  localparam int RST_BIT  = 7;
  localparam int CODE_LSB = 8;
  localparam int MASK_LSB = 16;

  typedef struct packed {
    logic [NUM_CH-1:0] mask;
    logic [CODE_W-1:0] code;
    logic              rst_pend;
    logic              khz_en;
    logic              upd_en;
    logic              en;
  } ctl_t;

  // Non-linear code scale: doubling up to 32, then steps of 16, capped at 144.
  function automatic logic [DLY_W-1:0] code_to_cycles(input logic [CODE_W-1:0] c);
    logic [DLY_W-1:0] r;
    case (c)
      4'd0:    r = 8'd0;
      4'd1:    r = 8'd1;
      4'd2:    r = 8'd2;
      4'd3:    r = 8'd4;
      4'd4:    r = 8'd8;
      4'd5:    r = 8'd16;
      4'd6:    r = 8'd32;
      4'd7:    r = 8'd48;
      4'd8:    r = 8'd64;
      4'd9:    r = 8'd80;
      4'd10:   r = 8'd96;
      4'd11:   r = 8'd112;
      4'd12:   r = 8'd128;
      default: r = 8'd144;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/evdly_ctl_reg.sv
module evdly_ctl_reg
  import evdly_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata
);
  ctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr) begin
        ctl_q.en     <= wdata[EN_BIT];
        ctl_q.upd_en <= wdata[UPD_BIT];
        ctl_q.khz_en <= wdata[KHZ_BIT];
        ctl_q.code   <= wdata[CODE_LSB +: CODE_W];
        ctl_q.mask   <= wdata[MASK_LSB +: NUM_CH];
      end
      // pending request lives one cycle, re-armed only by a fresh write of 1
      ctl_q.rst_pend <= wr & wdata[RST_BIT];
    end
  end

  always_comb begin
    rdata                         = '0;
    rdata[EN_BIT]                 = ctl_q.en;
    rdata[UPD_BIT]                = ctl_q.upd_en;
    rdata[KHZ_BIT]                = ctl_q.khz_en;
    rdata[RST_BIT]                = ctl_q.rst_pend;
    rdata[CODE_LSB +: CODE_W]     = ctl_q.code;
    rdata[MASK_LSB +: NUM_CH]     = ctl_q.mask;
  end

  assign ctl = ctl_q;

  a_r9_pend_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.rst_pend && !(wr && wdata[RST_BIT])) |=> !rdata[RST_BIT]);
endmodule

// File: rtl/evdly_rtc_cnt.sv
module evdly_rtc_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr_req,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clr_req) count_q <= '0;
    else if (en)      count_q <= count_q + 1'b1;
  end

  assign count = count_q;

  a_r9_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (count == '0));
  a_r8_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr_req) |=> $stable(count));
  a_r8_step_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr_req) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/evdly_chan.sv
module evdly_chan
  import evdly_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DLY_W-1:0]  dly_cycles,
  input  logic              evt_in,
  output logic              evt_out
);
  logic [DLY_W-1:0] remain_q;
  logic             pass_hit;
  logic             due_hit;
  logic             load_evt;

  assign pass_hit = en & evt_in & (dly_cycles == '0);
  assign due_hit  = en & (remain_q == DLY_W'(1));
  assign load_evt = en & evt_in & (dly_cycles != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (load_evt)         remain_q <= dly_cycles;
    else if (en && remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign evt_out = pass_hit | due_hit;

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !evt_out);
  a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (en && evt_in && dly_cycles == '0) |-> evt_out);
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(remain_q));
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (remain_q == $past(dly_cycles)));
endmodule

// File: rtl/evt_delay_combiner.sv
module evt_delay_combiner
  import evdly_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              lf_clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [31:0]       ctl_wdata,
  output logic [31:0]       ctl_rdata,
  input  logic [2:0]        chan_evt,
  output logic [2:0]        dly_evt,
  output logic              comb_evt,
  output logic [CNT_W-1:0]  rtc_count
);
  ctl_t              ctl;
  logic [DLY_W-1:0]  dly_cycles;
  logic [NUM_CH-1:0] masked_evt;

  evdly_ctl_reg u_ctl (
    .clk   (lf_clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl   (ctl),
    .rdata (ctl_rdata)
  );

  evdly_rtc_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (lf_clk),
    .rst_n   (rst_n),
    .en      (ctl.en),
    .clr_req (ctl.rst_pend),
    .count   (rtc_count)
  );

  assign dly_cycles = code_to_cycles(ctl.code);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    evdly_chan u_chan (
      .clk        (lf_clk),
      .rst_n      (rst_n),
      .en         (ctl.en),
      .dly_cycles (dly_cycles),
      .evt_in     (chan_evt[i]),
      .evt_out    (dly_evt[i])
    );
  end

  assign masked_evt = dly_evt & ctl.mask;
  assign comb_evt   = |masked_evt;

  a_r6_zero_mask: assert property (@(posedge lf_clk) disable iff (!rst_n)
    (ctl_rdata[MASK_LSB +: NUM_CH] == '0) |-> !comb_evt);
  a_r6_comb_needs_source: assert property (@(posedge lf_clk) disable iff (!rst_n)
    comb_evt |-> (dly_evt != '0));
  a_r10_reserved_zero: assert property (@(posedge lf_clk) disable iff (!rst_n)
    (ctl_rdata & 32'hFFF8_F078) == 32'h0);
endmodule

// File: tb/sim_evt_delay_combiner.sv
module sim_evt_delay_combiner;
  logic        lf_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic [2:0]  chan_evt = '0;
  logic [2:0]  dly_evt;
  logic        comb_evt;
  logic [31:0] rtc_count;

  evt_delay_combiner u0 (
    .lf_clk(lf_clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .chan_evt(chan_evt), .dly_evt(dly_evt),
    .comb_evt(comb_evt), .rtc_count(rtc_count)
  );

  always #4 lf_clk = ~lf_clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit     m_en, m_upd, m_khz, m_pend;
  int     m_code, m_mask;
  longint m_cnt;
  longint ecyc;
  longint due [3];

  function automatic int ref_delay(int c);
    if (c == 0) return 0;
    if (c <= 6) return 1 << (c - 1);
    if (c >= 13) return 144;
    return 16 * (c - 4);
  endfunction

  task automatic check(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge lf_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_upd = 0; m_khz = 0; m_pend = 0; m_code = 0; m_mask = 0;
      m_cnt = 0; ecyc = 0;
      foreach (due[i]) due[i] = -1;
    end else begin
      int d;
      d = ref_delay(m_code);
      if (m_pend) m_cnt = 0;
      else if (m_en) m_cnt = (m_cnt + 1) & 64'hFFFF_FFFF;
      if (m_en) begin
        for (int i = 0; i < 3; i++)
          if (chan_evt[i] && d > 0) due[i] = ecyc + d;
        ecyc++;
      end
      m_pend = ctl_wr && ctl_wdata[7];
      if (ctl_wr) begin
        m_en = ctl_wdata[0]; m_upd = ctl_wdata[1]; m_khz = ctl_wdata[2];
        m_code = int'(ctl_wdata[11:8]); m_mask = int'(ctl_wdata[18:16]);
      end
    end
  end

  always @(negedge lf_clk) begin
    if (!done) begin
      logic [2:0] exp_d;
      logic [31:0] exp_r;
      bit exp_c;
      for (int i = 0; i < 3; i++)
        exp_d[i] = m_en && ((due[i] == ecyc) || (m_code == 0 && chan_evt[i]));
      exp_c = |(exp_d & m_mask[2:0]);
      exp_r = {13'b0, m_mask[2:0], 4'b0, m_code[3:0], m_pend, 4'b0, m_khz, m_upd, m_en};
      check("dly_evt", dly_evt, exp_d);
      check("comb_evt", comb_evt, exp_c);
      check("rtc_count", rtc_count, m_cnt);
      check("ctl_rdata", ctl_rdata, exp_r);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge lf_clk);
    #1;
  endtask

  task automatic wr(logic [31:0] v);
    ctl_wr = 1; ctl_wdata = v;
    step(1);
    ctl_wr = 0; ctl_wdata = '0;
  endtask

  task automatic pulse(logic [2:0] v);
    chan_evt = v;
    step(1);
    chan_evt = '0;
  endtask

  function automatic logic [31:0] ctlw(int code, int mask, bit en);
    return {13'b0, mask[2:0], 4'b0, code[3:0], 7'b0, en};
  endfunction

  initial begin
    cur_req = "R1";
    step(3);
    rst_n = 1;
    step(2);
    // R10: field layout and reserved bits, including option bits
    cur_req = "R10";
    wr(32'hFFFF_FF7F);
    step(2);
    wr(ctlw(0, 7, 1) | 32'h6);
    step(2);
    // R4: code 0 pass-through, all channels
    cur_req = "R4";
    pulse(3'b101); step(1); pulse(3'b010); step(2);
    // R2 R11: sweep codes 1..13
    for (int c = 1; c <= 13; c++) begin
      cur_req = "R2 R11";
      wr(ctlw(c, 7, 1));
      pulse(3'(1 << (c % 3)));
      step(ref_delay(c) + 3);
    end
    // R3: codes 14, 15
    for (int c = 14; c <= 15; c++) begin
      cur_req = "R3";
      wr(ctlw(c, 7, 1));
      pulse(3'b011);
      step(150);
    end
    // R5: restart mid-count, and collision at due cycle
    cur_req = "R5";
    wr(ctlw(4, 7, 1));
    pulse(3'b001); step(3); pulse(3'b001); step(12);
    pulse(3'b010); step(6); pulse(3'b010); step(12);
    // R6: mask patterns
    wr(ctlw(2, 0, 1));
    for (int m = 0; m < 8; m++) begin
      cur_req = "R6";
      wr(ctlw(2, m, 1));
      pulse(3'b111); step(1); pulse(3'b001); step(1); pulse(3'b100); step(4);
    end
    // R7 R8: freeze mid-count, inputs ignored while off
    cur_req = "R7 R8";
    wr(ctlw(5, 7, 1));
    pulse(3'b111); step(4);
    wr(ctlw(5, 7, 0));
    pulse(3'b010); step(10); pulse(3'b100); step(3);
    wr(ctlw(0, 7, 0));
    pulse(3'b111); step(2);
    wr(ctlw(5, 7, 1));
    step(20);
    // R9: counter reset, also while disabled, and write of 0 to bit 7
    cur_req = "R9";
    wr(ctlw(3, 7, 1) | 32'h80);
    step(5);
    wr(ctlw(3, 7, 1));
    step(3);
    wr(ctlw(3, 7, 0) | 32'h80);
    step(3);
    wr(ctlw(3, 7, 1) | 32'h80);
    wr(ctlw(3, 7, 1) | 32'h80);
    step(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge lf_clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule